// File: doc/BRIEF.md
# Pulse-Window Power Gating Controller

This block drives the enable lines of the receive chain in a carrier-less impulse radio: the low-noise amplifier, the correlator, the matched filter, the delay-line timing unit and the converter. Because received energy arrives only as short, widely spaced pulses, the chain is powered only in a short window around each pulse and is held off in the gaps between pulses. The decisions are based on a pulse strobe that the delay-locked timing unit produces, not on a free-running timer.

Each strobe opens a window that stays open for a programmable number of cycles. The block also measures the spacing between two consecutive strobes. From that spacing it predicts the next strobe and opens the enables a programmable number of cycles before that strobe arrives. If the receiver-active flag drops, everything closes on the next edge and the measured spacing is discarded. A bypass input holds all enables on, so that the non-switching mode can be compared with the gated mode. While acquisition is unlocked, the timing unit stays enabled so that it can keep searching. All control pins are plain level signals; no data stream passes through the block.

Top module: `pwg_ctrl`

## Requirements
- R1: While reset is asserted, every bit of `blk_en` and `win_flag` is 0, whatever the other inputs are.
- R2: With `rx_active` high, a strobe sampled at an edge sets the gated enables after that edge, and they stay high for `win_cycles` further cycles (`win_cycles`+1 cycles in total) unless another term keeps them on.
- R3: Once two strobes have been seen with spacing P (in edges), the gated enables rise after the edge that falls `lead_cycles` edges before the predicted strobe edge, and they stay on through the predicted strobe.
- R4: No lead window exists until two strobes have been seen. If a predicted strobe does not come, the lead window closes after the predicted edge and the enables go low once the post-strobe window has ended.
- R5: A low `rx_active` at an edge clears every enable and `win_flag` after that edge. Strobes are ignored while it is low, and the measured spacing is discarded, so two new strobes are needed before any prediction.
- R6: With `rx_active` and `bypass` both high, every `blk_en` bit is 1 after the next edge.
- R7: With `rx_active` high and `acq_locked` low, `blk_en[3]` (the timing unit) is 1 after the next edge, even outside any window.
- R8: `win_flag` reports the gating window alone: it is 1 exactly when the strobe, post-strobe or lead term was true at the previous edge, and neither bypass nor an unlocked state affects it.
- R9: Bit assignment of `blk_en`: bit 0 is the amplifier, bit 1 the correlator, bit 2 the matched filter, bit 3 the timing unit and bit 4 the converter. Bits 0, 1, 2 and 4 always carry the same value.
- R10: The spacing counter is `CNT_W` bits wide and saturates. A spacing of up to 2^CNT_W-1 edges is predicted, and a longer spacing gives no lead window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_active | input | 1 | Receiver active; low closes everything |
| bypass | input | 1 | Hold all enables on (non-switching mode) |
| acq_locked | input | 1 | Timing acquisition has locked |
| pulse_strobe | input | 1 | One-cycle strobe per received pulse slot from the timing unit |
| lead_cycles | input | CNT_W | Cycles that enables open ahead of a predicted strobe |
| win_cycles | input | CNT_W | Cycles that enables stay open after a strobe |
| blk_en | output | 5 | Per-block enables, ordered as in R9 |
| win_flag | output | 1 | Gating window currently open |

## Verification
The main function is driven with a single isolated strobe, which shows the post-strobe window alone. A steady train with spacing 20, and a second train with spacing 9 and different lead and window settings, show the prediction and separate an off-by-one in the lead edge from one in the window length. A train with one strobe left out shows how a missed pulse closes. Spacings of 300 and 255 sit on either side of the counter limit. A reference model in the bench computes the enables for every cycle from strobe edge indices and compares them with the outputs.

// File: rtl/pwg_pkg.sv
package pwg_pkg;
  // Number of controlled receive-chain blocks and the slot of the timing unit
  localparam int NUM_BLK = 5;
  localparam int IDX_TIM = 3;
endpackage

// File: rtl/pwg_interval_tracker.sv
module pwg_interval_tracker #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_active,
  input  logic             pulse_strobe,
  output logic [CNT_W-1:0] since_o,
  output logic [CNT_W-1:0] period_o,
  output logic             seen_o,
  output logic             period_ok_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] since_q, period_q;
  logic             seen_q, pok_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_q  <= '0;
      period_q <= '0;
      seen_q   <= 1'b0;
      pok_q    <= 1'b0;
    end else if (!rx_active) begin
      since_q <= '0;
      seen_q  <= 1'b0;
      pok_q   <= 1'b0;
    end else if (pulse_strobe) begin
      since_q  <= '0;
      seen_q   <= 1'b1;
      pok_q    <= seen_q && (since_q != CNT_MAX);
      period_q <= since_q + 1'b1;
    end else if (since_q != CNT_MAX) begin
      since_q <= since_q + 1'b1;
    end
  end

  assign since_o     = since_q;
  assign period_o    = period_q;
  assign seen_o      = seen_q;
  assign period_ok_o = pok_q;

  // R10
  sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_active && !pulse_strobe && since_q == CNT_MAX) |=> since_q == CNT_MAX);

  // R5
  forget_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_active |=> (!seen_q && !pok_q));

  // R4
  pred_needs_two_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_active && pulse_strobe && !seen_q) |=> !pok_q);
endmodule

// File: rtl/pwg_window_calc.sv
module pwg_window_calc #(
  parameter int CNT_W = 8
) (
  input  logic             rx_active,
  input  logic             pulse_strobe,
  input  logic [CNT_W-1:0] since,
  input  logic [CNT_W-1:0] period,
  input  logic             seen,
  input  logic             period_ok,
  input  logic [CNT_W-1:0] lead_cyc,
  input  logic [CNT_W-1:0] win_cyc,
  output logic             gate_o
);
  localparam int EW = CNT_W + 1;

  logic [EW-1:0] next_pos, reach, per_ext;
  logic          lead_hit, post_hit;

  always_comb begin
    per_ext  = {1'b0, period};
    next_pos = {1'b0, since} + EW'(1);
    reach    = next_pos + {1'b0, lead_cyc};
    lead_hit = period_ok && (reach >= per_ext) && (next_pos <= per_ext);
    post_hit = seen && (since < win_cyc);
    gate_o   = rx_active && (pulse_strobe || post_hit || lead_hit);
  end
endmodule

// File: rtl/pwg_enable_bank.sv
module pwg_enable_bank #(
  parameter int NUM     = 5,
  parameter int TIM_IDX = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           rx_active,
  input  logic           bypass,
  input  logic           acq_locked,
  input  logic           gate,
  output logic [NUM-1:0] en_o,
  output logic           flag_o
);
  logic           front_want, tim_want;
  logic [NUM-1:0] en_nxt, en_q;
  logic           flag_q;

  assign front_want = rx_active && (bypass || gate);
  assign tim_want   = rx_active && (bypass || gate || !acq_locked);

  for (genvar i = 0; i < NUM; i++) begin : g_slot
    if (i == TIM_IDX) begin : g_tim
      assign en_nxt[i] = tim_want;
    end else begin : g_front
      assign en_nxt[i] = front_want;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      flag_q <= 1'b0;
    end else begin
      en_q   <= en_nxt;
      flag_q <= gate;
    end
  end

  assign en_o   = en_q;
  assign flag_o = flag_q;

  // R5
  rx_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_active |=> (en_q == '0 && !flag_q));

  // R6
  bypass_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_active && bypass) |=> (&en_q));

  // R7
  search_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_active && !acq_locked) |=> en_q[TIM_IDX]);
endmodule

// File: rtl/pwg_ctrl.sv
module pwg_ctrl
  import pwg_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rx_active,
  input  logic               bypass,
  input  logic               acq_locked,
  input  logic               pulse_strobe,
  input  logic [CNT_W-1:0]   lead_cycles,
  input  logic [CNT_W-1:0]   win_cycles,
  output logic [NUM_BLK-1:0] blk_en,
  output logic               win_flag
);
  logic [CNT_W-1:0] since, period;
  logic             seen, period_ok, gate;

  pwg_interval_tracker #(.CNT_W(CNT_W)) u_track (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_active   (rx_active),
    .pulse_strobe(pulse_strobe),
    .since_o     (since),
    .period_o    (period),
    .seen_o      (seen),
    .period_ok_o (period_ok)
  );

  pwg_window_calc #(.CNT_W(CNT_W)) u_calc (
    .rx_active   (rx_active),
    .pulse_strobe(pulse_strobe),
    .since       (since),
    .period      (period),
    .seen        (seen),
    .period_ok   (period_ok),
    .lead_cyc    (lead_cycles),
    .win_cyc     (win_cycles),
    .gate_o      (gate)
  );

  pwg_enable_bank #(.NUM(NUM_BLK), .TIM_IDX(IDX_TIM)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_active (rx_active),
    .bypass    (bypass),
    .acq_locked(acq_locked),
    .gate      (gate),
    .en_o      (blk_en),
    .flag_o    (win_flag)
  );

  // R2
  strobe_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_active && pulse_strobe) |=> (blk_en[0] && blk_en[1] && blk_en[2] && blk_en[4] && win_flag));

  // R9
  front_same_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_en[0] == blk_en[1]) && (blk_en[1] == blk_en[2]) && (blk_en[2] == blk_en[4]));
endmodule

// File: tb/sim_pwg_ctrl.sv
`timescale 1ns/1ps
module sim_pwg_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_active = 1'b0, bypass = 1'b0, acq_locked = 1'b1, pulse_strobe = 1'b0;
  logic [7:0] lead_cycles = 8'd2, win_cycles = 8'd3;
  logic [4:0] blk_en;
  logic       win_flag;

  always #4 clk = ~clk;

  pwg_ctrl #(.CNT_W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .rx_active(rx_active), .bypass(bypass),
    .acq_locked(acq_locked), .pulse_strobe(pulse_strobe),
    .lead_cycles(lead_cycles), .win_cycles(win_cycles),
    .blk_en(blk_en), .win_flag(win_flag)
  );

  typedef struct packed { logic [4:0] en; logic flag; } exp_t;
  exp_t  exp_q[$];
  string tag_q[$];
  string cur_tag = "R2";
  int    total = 0, bad = 0;
  bit    finished = 1'b0;

  // reference model state, in edge indices
  int cyc = 0, last_l = 0, per = 0;
  bit seen = 1'b0, pok = 1'b0;

  task automatic step(input bit stb);
    int d;
    bit g, f, t;
    exp_t e;
    pulse_strobe = stb;
    @(posedge clk);
    d = cyc - last_l;
    g = rx_active && (stb || (seen && d <= int'(win_cycles)) ||
        (pok && (d + int'(lead_cycles) >= per) && d <= per));
    f = rx_active && (bypass || g);
    t = rx_active && (bypass || g || !acq_locked);
    e.en   = {f, t, f, f, f};
    e.flag = g;
    exp_q.push_back(e);
    tag_q.push_back(cur_tag);
    if (!rx_active) begin
      seen = 1'b0;
      pok  = 1'b0;
    end else if (stb) begin
      if (seen) begin
        per = d;
        pok = (d <= 255);
      end else begin
        pok = 1'b0;
      end
      last_l = cyc;
      seen   = 1'b1;
    end
    cyc++;
    @(negedge clk);
  endtask

  // monitor: pops the expected item pushed at the preceding edge
  always @(negedge clk) begin : mon
    exp_t  e;
    string t;
    if (exp_q.size() > 0) begin
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      total++;
      if (blk_en !== e.en) begin
        bad++;
        $display("FAIL %s cyc=%0d blk_en actual=%b expected=%b", t, cyc, blk_en, e.en);
      end
      total++;
      if (win_flag !== e.flag) begin
        bad++;
        $display("FAIL R8 (%s) cyc=%0d win_flag actual=%b expected=%b", t, cyc, win_flag, e.flag);
      end
    end
  end

  task automatic train(input int period, input int count);
    for (int k = 0; k < count; k++) begin
      step(1'b1);
      repeat (period - 1) step(1'b0);
    end
  endtask

  initial begin
    // R1: reset holds everything low even with bypass requested
    rx_active = 1'b1;
    bypass    = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    total++;
    if (blk_en !== 5'b0 || win_flag !== 1'b0) begin
      bad++;
      $display("FAIL R1 reset outputs actual=%b/%b expected=00000/0", blk_en, win_flag);
    end
    bypass = 1'b0;
    rst_n  = 1'b1;
    @(negedge clk);

    // R2: isolated strobe, window only
    cur_tag = "R2";
    step(1'b1);
    repeat (10) step(1'b0);

    // R3: steady trains, two settings
    cur_tag = "R3";
    train(20, 3);
    repeat (5) step(1'b0);
    lead_cycles = 8'd4;
    win_cycles  = 8'd1;
    train(9, 4);

    // R4: missed strobe
    cur_tag = "R4";
    step(1'b1);
    repeat (8) step(1'b0);
    repeat (30) step(1'b0);

    // R5: receiver drop mid window forgets the spacing
    cur_tag = "R5";
    train(9, 2);
    step(1'b0);
    rx_active = 1'b0;
    step(1'b1);
    repeat (3) step(1'b0);
    rx_active = 1'b1;
    step(1'b1);
    repeat (12) step(1'b0);

    // R10: spacing beyond and at the counter limit
    cur_tag = "R10";
    lead_cycles = 8'd2;
    win_cycles  = 8'd3;
    train(300, 3);
    train(255, 3);
    step(1'b1);
    repeat (4) step(1'b0);

    // R6: bypass holds all on, receiver drop still wins
    cur_tag = "R6";
    bypass = 1'b1;
    repeat (6) step(1'b0);
    step(1'b1);
    repeat (4) step(1'b0);
    rx_active = 1'b0;
    repeat (3) step(1'b0);
    rx_active = 1'b1;
    bypass    = 1'b0;
    repeat (3) step(1'b0);

    // R7 and R9: unlocked keeps only bit 3 on between windows
    cur_tag = "R7 R9";
    acq_locked = 1'b0;
    repeat (5) step(1'b0);
    step(1'b1);
    repeat (6) step(1'b0);
    acq_locked = 1'b1;
    repeat (3) step(1'b0);

    @(negedge clk);
    @(negedge clk);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1000000;
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule